// File: doc/BRIEF.md
# Four-to-One XOR Whitener with Pseudo-Random Mask

This block conditions a raw random bit stream. Each cycle in which `raw_valid` is high, one raw bit is taken in. Every four accepted bits are folded into a single bit by XOR. That bit is then XORed with the next bit of a maximal-length 16-bit linear feedback shift register. The result is presented on `out_bit` together with a one-cycle `out_valid` strobe.

The output rate is therefore exactly one quarter of the accepted raw rate. A downstream consumer can treat `out_valid` as an enable at the divided rate. Cycles in which `raw_valid` is low do not count toward a group, so gaps in the raw stream only stretch the output spacing.

Top module: `wh_postproc`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, `out_valid` is 0 and `out_bit` is 0.
- R2: `out_valid` is high for exactly one cycle, in the cycle right after the clock edge that accepts the fourth raw bit of a group. It is never high in two consecutive cycles.
- R3: When `out_valid` is high, `out_bit` equals the XOR of the four raw bits of that group, XORed with the current mask bit.
- R4: The mask bit is bit 15 (MSB) of a 16-bit state. The state is seeded with 0xACE1 on reset. On each step it shifts left and takes as its new bit 0 the XOR of bits 15, 13, 12 and 10. After reset, the first three outputs for all-zero raw input are therefore 1, 0, 1.
- R5: The mask state advances only on the edge that completes a group. Any other cycle, with or without raw data, leaves it unchanged.
- R6: A cycle with `raw_valid` low is ignored: its `raw_bit` enters no group and the group position does not advance.
- R7: The fold starts from zero at every group, so no bit of one group affects the output of another.
- R8: While `out_valid` is low, `out_bit` holds its last value.
- R9: Reset asserted in the middle of a group discards the partial group and reseeds the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_bit | input | 1 | Raw random bit |
| raw_valid | input | 1 | Raw bit qualifier |
| out_bit | output | 1 | Whitened output bit |
| out_valid | output | 1 | One-cycle strobe marking a new output bit |

## Verification
Two things can land on the same edge: the absorption of a group's fourth bit and the step of the mask register. On that edge the output must take the mask bit from before the step, while the register moves on for the next group. Fourth bits are driven both back-to-back and after long stretches of `raw_valid` low with `raw_bit` toggling. A behavioural reference model, compared every clock, judges whether the mask was taken and stepped exactly once per group and never during a gap.

// File: rtl/wh_pkg.sv
package wh_pkg;
    localparam int GROUP_LEN = 4;
    localparam int MASK_W    = 16;
    // taps 16,14,13,11 -> bit positions 15,13,12,10
    localparam logic [MASK_W-1:0] MASK_TAPS = 16'hB400;
    localparam logic [MASK_W-1:0] MASK_SEED = 16'hACE1;

    typedef struct packed {
        logic done;     // group completes on this edge
        logic folded;   // XOR of the whole group, valid with done
    } fold_t;

    function automatic logic [MASK_W-1:0] mask_step(input logic [MASK_W-1:0] s,
                                                    input logic [MASK_W-1:0] taps);
        return {s[MASK_W-2:0], ^(s & taps)};
    endfunction
endpackage

// File: rtl/wh_fold.sv
module wh_fold
    import wh_pkg::*;
#(
    parameter int GLEN = GROUP_LEN,
    localparam int PH_W = (GLEN > 1) ? $clog2(GLEN) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            raw_bit,
    input  logic            raw_valid,
    output fold_t           fold,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] LAST = PH_W'(GLEN - 1);

    logic [PH_W-1:0] phase_q;
    logic            acc_q;
    logic            last_slot;

    assign last_slot   = (phase_q == LAST);
    assign fold.done   = raw_valid && last_slot;
    assign fold.folded = acc_q ^ raw_bit;
    assign phase       = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            acc_q   <= 1'b0;
        end else if (raw_valid) begin
            if (last_slot) begin
                phase_q <= '0;
                acc_q   <= 1'b0;
            end else begin
                phase_q <= phase_q + 1'b1;
                acc_q   <= acc_q ^ raw_bit;
            end
        end
    end
endmodule

// File: rtl/wh_mask.sv
module wh_mask
    import wh_pkg::*;
#(
    parameter int              W    = MASK_W,
    parameter logic [W-1:0]    TAPS = MASK_TAPS,
    parameter logic [W-1:0]    SEED = MASK_SEED
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic         mask_bit,
    output logic [W-1:0] state
);
    logic [W-1:0] st_q;

    always_ff @(posedge clk) begin
        if (rst)       st_q <= SEED;
        else if (step) st_q <= mask_step(st_q, TAPS);
    end

    assign mask_bit = st_q[W-1];
    assign state    = st_q;
endmodule

// File: rtl/wh_postproc.sv
module wh_postproc
    import wh_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic raw_bit,
    input  logic raw_valid,
    output logic out_bit,
    output logic out_valid
);
    localparam int PH_W = (GROUP_LEN > 1) ? $clog2(GROUP_LEN) : 1;

    fold_t              grp;
    logic [PH_W-1:0]    grp_phase;
    logic               mask_bit;
    logic [MASK_W-1:0]  mask_state;

    wh_fold #(.GLEN(GROUP_LEN)) u_fold (
        .clk       (clk),
        .rst       (rst),
        .raw_bit   (raw_bit),
        .raw_valid (raw_valid),
        .fold      (grp),
        .phase     (grp_phase)
    );

    wh_mask #(.W(MASK_W), .TAPS(MASK_TAPS), .SEED(MASK_SEED)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .step     (grp.done),
        .mask_bit (mask_bit),
        .state    (mask_state)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_bit   <= 1'b0;
            out_valid <= 1'b0;
        end else begin
            out_valid <= grp.done;
            if (grp.done) out_bit <= grp.folded ^ mask_bit;
        end
    end
endmodule

// File: rtl/wh_postproc_chk.sv
module wh_postproc_chk #(
    parameter int PH_W = 2,
    parameter int GLEN = 4,
    parameter int W    = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            raw_valid,
    input logic            out_valid,
    input logic            out_bit,
    input logic [PH_W-1:0] phase,
    input logic [W-1:0]    lfsr_state
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !out_bit));

    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    assert_pulse_after_last_R2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(rst)) |-> ($past(raw_valid) && $past(phase) == PH_W'(GLEN - 1)));

    assert_mask_nonzero_R4: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != '0);

    assert_mask_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(lfsr_state));

    assert_gap_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !raw_valid |=> $stable(phase));

    assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(out_bit));
endmodule

bind wh_postproc wh_postproc_chk #(
    .PH_W ((wh_pkg::GROUP_LEN > 1) ? $clog2(wh_pkg::GROUP_LEN) : 1),
    .GLEN (wh_pkg::GROUP_LEN),
    .W    (wh_pkg::MASK_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .raw_valid  (raw_valid),
    .out_valid  (out_valid),
    .out_bit    (out_bit),
    .phase      (grp_phase),
    .lfsr_state (mask_state)
);

// File: tb/wh_postproc_bench.sv
module wh_postproc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic raw_bit = 1'b0;
    logic raw_valid = 1'b0;
    logic out_bit, out_valid;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // behavioural reference
    int  m_cnt, m_acc, m_lfsr;
    bit  exp_valid, exp_bit;
    bit  obs_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wh_postproc u_wh_postproc (
        .clk(clk), .rst(rst), .raw_bit(raw_bit), .raw_valid(raw_valid),
        .out_bit(out_bit), .out_valid(out_valid)
    );

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_cnt = 0; m_acc = 0; m_lfsr = 'hACE1;
            exp_valid = 0; exp_bit = 0;
        end else begin
            exp_valid = 0;
            if (raw_valid) begin
                m_acc = m_acc ^ int'(raw_bit);
                m_cnt++;
                if (m_cnt == 4) begin
                    exp_bit   = bit'(m_acc ^ ((m_lfsr >> 15) & 1));
                    exp_valid = 1;
                    m_lfsr = ((m_lfsr << 1) | (((m_lfsr >> 15) ^ (m_lfsr >> 13) ^
                               (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1)) & 'hFFFF;
                    m_cnt = 0; m_acc = 0;
                end
            end
        end
    end

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            obs_q.delete();
        end else begin
            check(out_valid == exp_valid, "R2 out_valid", out_valid, exp_valid);
            if (exp_valid) check(out_bit == exp_bit, "R3 out_bit", out_bit, exp_bit);
            else           check(out_bit == exp_bit, "R8 out_bit hold", out_bit, exp_bit);
            if (out_valid) obs_q.push_back(out_bit);
        end
    end

    task automatic send(input bit b, input bit v);
        @(negedge clk);
        raw_bit = b; raw_valid = v;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; raw_valid = 1'b0; raw_bit = 1'b0;
        repeat (2) @(negedge clk);
        check(out_valid == 0 && out_bit == 0, "R1 reset outputs", {out_valid, out_bit}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 0 && out_bit == 0, "R1 first cycle after reset", {out_valid, out_bit}, 0);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        do_reset();

        // R4: all-zero input exposes the mask bits 1,0,1
        for (int i = 0; i < 12; i++) send(1'b0, 1'b1);
        send(1'b0, 1'b0);
        send(1'b0, 1'b0);
        check(obs_q.size() == 3, "R4 pulse count", obs_q.size(), 3);
        if (obs_q.size() == 3) begin
            check(obs_q[0] == 1, "R4 mask bit 0", obs_q[0], 1);
            check(obs_q[1] == 0, "R4 mask bit 1", obs_q[1], 0);
            check(obs_q[2] == 1, "R4 mask bit 2", obs_q[2], 1);
        end

        // R7: group 1,0,0,0 then 0,0,0,0 -> 1^1=0, then 0^0=0
        do_reset();
        send(1'b1, 1'b1); for (int i = 0; i < 7; i++) send(1'b0, 1'b1);
        send(1'b0, 1'b0); send(1'b0, 1'b0);
        check(obs_q.size() == 2, "R7 pulse count", obs_q.size(), 2);
        if (obs_q.size() == 2) check(obs_q[1] == 0, "R7 fold cleared per group", obs_q[1], 0);

        // R6/R5: gaps with toggling raw_bit between group bits
        do_reset();
        send(1'b1, 1'b1); send(1'b1, 1'b1); send(1'b0, 1'b1);
        for (int i = 0; i < 9; i++) send(i[0], 1'b0);
        n = obs_q.size();
        check(n == 0, "R6 no output during gap", n, 0);
        send(1'b0, 1'b1);            // fourth bit: fold 0, mask 1
        send(1'b1, 1'b0);
        send(1'b1, 1'b0);
        check(obs_q.size() == 1, "R6 gap ignored", obs_q.size(), 1);
        if (obs_q.size() == 1) check(obs_q[0] == 1, "R5 mask not stepped in gap", obs_q[0], 1);

        // R9: reset mid-group, then zeros give 1,0,1 again
        send(1'b1, 1'b1); send(1'b0, 1'b1);
        do_reset();
        for (int i = 0; i < 12; i++) send(1'b0, 1'b1);
        send(1'b0, 1'b0); send(1'b0, 1'b0);
        check(obs_q.size() == 3, "R9 pulses after mid-group reset", obs_q.size(), 3);
        if (obs_q.size() == 3)
            check(obs_q[0] == 1 && obs_q[1] == 0 && obs_q[2] == 1, "R9 reseed",
                  {obs_q[0], obs_q[1], obs_q[2]}, 5);

        // R2/R3 mixed random traffic, model compared each clock
        for (int i = 0; i < 3000; i++) send(1'($urandom), 1'(($urandom % 4) != 0));
        for (int i = 0; i < 400; i++) send(1'($urandom), 1'b1);
        send(1'b0, 1'b0); send(1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule